// File: doc/BRIEF.md
# Serial Transmit Path with Line Break

This block is the sending half of a high-speed asynchronous serial port. Bytes arrive over a valid/ready write stream and wait in a 64-deep queue. A serializer sends each byte as a fixed frame: one start bit at logic 0, eight data bits with the least significant bit first, and one stop bit at logic 1. The line rests high between frames. The bit period comes from an 8-bit rate input. Each bit lasts (rate+1)*14 clock cycles, so a rate of 0xFF gives the slowest speed.

The block reports an occupancy count. That count includes the byte currently on the wire until its stop bit has finished, so a count of zero means the line is truly idle. A 2-bit trigger code chooses a low-water mark. When the count drops to that mark, the block raises a one-cycle request pulse, which a refill agent can use to top the queue up. A break input forces the line low for as long as it is held, and it stops any new frame from starting.

Back-pressure works as follows. A byte is taken on a clock edge only when `wr_valid` and `wr_ready` are both high. `wr_ready` falls when the count reaches the queue depth. A byte offered while `wr_ready` is low is not taken, and the producer keeps it until `wr_ready` returns.

Top module: `hs_uart_tx`

## Requirements
- R1: After reset, `txd` is 1, `tx_level` is 0, `wr_ready` is 1 and `tx_req` is 0.
- R2: Every bit of a frame lasts exactly (rate+1)*14 clock cycles. For example, rate 0 gives 14 cycles and rate 2 gives 42 cycles.
- R3: A frame is a 0 start bit, then the 8 data bits least significant first, then a 1 stop bit. The line is 1 whenever no frame or break is active.
- R4: `tx_level` equals the number of queued bytes plus one while a frame is on the wire, up to the end of its stop bit. It changes by at most one per cycle, and it never exceeds the depth of 64.
- R5: A handshake with `wr_valid` and `wr_ready` both high appends `wr_data` to the queue. `wr_ready` is 0 exactly when `tx_level` is 64. A byte offered while `wr_ready` is 0 leaves `tx_level` unchanged.
- R6: Bytes leave the line in the same order they were accepted.
- R7: `tx_req` pulses high for one cycle when `tx_level` moves from above the threshold to at or below it. The threshold for `tx_trig` codes 0, 1, 2 and 3 is 0, 4, 8 and 16 entries respectively.
- R8: While `brk_en` is 1, `txd` is 0 on every cycle and no new frame begins, so queued bytes stay queued. A frame already under way finishes internally and its byte is counted out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_valid | input | 1 | Write byte is offered |
| wr_ready | output | 1 | Queue can take a byte this cycle |
| wr_data | input | 8 | Byte to queue |
| rate | input | 8 | Bit period select, (rate+1)*14 clocks |
| brk_en | input | 1 | Force line low and hold off new frames |
| tx_trig | input | 2 | Low-water code: 0, 4, 8 or 16 entries |
| txd | output | 1 | Serial line |
| tx_level | output | 8 | Queued plus in-flight byte count |
| tx_req | output | 1 | One-cycle pulse on reaching low-water mark |

## Verification
The bound checker checks the following on every cycle:
- the count stays within the depth and never moves by more than one;
- a refused byte never raises the count;
- the line is high when the count is zero and no break is held;
- each request pulse lasts a single cycle and occurs only at or below the selected mark.

Some behaviours can only be shown by the bench's directed scenarios:
- bit timing at several rate values;
- bit order within a frame and byte order across frames;
- the exact count seen while the stop bit is still on the wire;
- that each trigger code yields exactly one pulse at its own mark during a drain;
- that a break holds the line low and keeps queued bytes from leaving.

// File: rtl/hs_uart_tx_pkg.sv
package hs_uart_tx_pkg;
  localparam int BYTE_W  = 8;
  localparam int LEVEL_W = 8;
  localparam int FRAME_BITS = 10;

  typedef logic [BYTE_W-1:0]  byte_t;
  typedef logic [LEVEL_W-1:0] level_t;

  // Low-water mark chosen by the 2-bit trigger code.
  function automatic level_t trig_threshold(input logic [1:0] code);
    level_t thr;
    unique case (code)
      2'd0:    thr = level_t'(0);
      2'd1:    thr = level_t'(4);
      2'd2:    thr = level_t'(8);
      default: thr = level_t'(16);
    endcase
    return thr;
  endfunction
endpackage

// File: rtl/hs_uart_tx_fifo.sv
module hs_uart_tx_fifo #(
  parameter int DEPTH = 64,
  parameter int WIDTH = 8,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic [WIDTH-1:0] pop_data,
  output logic [CW-1:0]    count
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;

  function automatic logic [AW-1:0] next_ptr(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= next_ptr(wr_ptr);
      if (pop)  rd_ptr <= next_ptr(rd_ptr);
      unique case ({push, pop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

  assign pop_data = mem[rd_ptr];
endmodule

// File: rtl/hs_uart_tx_baud.sv
module hs_uart_tx_baud #(
  parameter int RATE_W   = 8,
  parameter int PRESCALE = 14,
  localparam int PW = $clog2(PRESCALE)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [RATE_W-1:0] rate,
  output logic              tick
);
  logic [PW-1:0]     pre;
  logic [RATE_W-1:0] div;
  logic              pre_last;

  assign pre_last = (pre == PW'(PRESCALE - 1));
  assign tick     = en && pre_last && (div == rate);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre <= '0;
      div <= '0;
    end else if (!en || tick) begin
      pre <= '0;
      div <= '0;
    end else if (pre_last) begin
      pre <= '0;
      div <= div + RATE_W'(1);
    end else begin
      pre <= pre + PW'(1);
    end
  end
endmodule

// File: rtl/hs_uart_tx_ser.sv
module hs_uart_tx_ser
  import hs_uart_tx_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  start,
  input  byte_t start_data,
  input  logic  tick,
  output logic  busy,
  output logic  line
);
  localparam int BW = $clog2(FRAME_BITS);

  logic [FRAME_BITS-1:0] shreg;
  logic [BW-1:0]         bitcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg  <= '1;
      bitcnt <= '0;
      busy   <= 1'b0;
    end else if (start) begin
      shreg  <= {1'b1, start_data, 1'b0};
      bitcnt <= '0;
      busy   <= 1'b1;
    end else if (busy && tick) begin
      if (bitcnt == BW'(FRAME_BITS - 1)) begin
        busy <= 1'b0;
      end else begin
        shreg  <= {1'b1, shreg[FRAME_BITS-1:1]};
        bitcnt <= bitcnt + BW'(1);
      end
    end
  end

  assign line = busy ? shreg[0] : 1'b1;
endmodule

// File: rtl/hs_uart_tx.sv
module hs_uart_tx
  import hs_uart_tx_pkg::*;
#(
  parameter int DEPTH    = 64,
  parameter int RATE_W   = 8,
  parameter int PRESCALE = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [7:0]        wr_data,
  input  logic [RATE_W-1:0] rate,
  input  logic              brk_en,
  input  logic [1:0]        tx_trig,
  output logic              txd,
  output logic [7:0]        tx_level,
  output logic              tx_req
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [CW-1:0] q_count;
  logic [CW-1:0] occupancy;
  byte_t         q_head;
  logic          accept, start, busy, tick, line;
  logic          low_now, low_q;

  assign accept    = wr_valid && wr_ready;
  assign start     = !busy && (q_count != '0) && !brk_en;
  assign occupancy = q_count + CW'(busy);
  assign wr_ready  = (occupancy != CW'(DEPTH));

  hs_uart_tx_fifo #(.DEPTH(DEPTH), .WIDTH(BYTE_W)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (accept),
    .push_data (wr_data),
    .pop       (start),
    .pop_data  (q_head),
    .count     (q_count)
  );

  hs_uart_tx_baud #(.RATE_W(RATE_W), .PRESCALE(PRESCALE)) u_baud (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (busy),
    .rate  (rate),
    .tick  (tick)
  );

  hs_uart_tx_ser u_ser (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .start_data (q_head),
    .tick       (tick),
    .busy       (busy),
    .line       (line)
  );

  assign txd      = brk_en ? 1'b0 : line;
  assign tx_level = LEVEL_W'(occupancy);

  // Low-water edge detect; starts "already low" so reset gives no pulse.
  assign low_now = (tx_level <= trig_threshold(tx_trig));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) low_q <= 1'b1;
    else        low_q <= low_now;
  end

  assign tx_req = low_now && !low_q;
endmodule

// File: rtl/hs_uart_tx_chk.sv
module hs_uart_tx_chk
  import hs_uart_tx_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_valid,
  input logic       wr_ready,
  input logic       brk_en,
  input logic [1:0] tx_trig,
  input logic       txd,
  input logic [7:0] tx_level,
  input logic       tx_req
);
  assert_level_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_level <= 8'(DEPTH));

  assert_level_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_level == $past(tx_level)) || (tx_level == $past(tx_level) + 8'd1) ||
    (tx_level + 8'd1 == $past(tx_level)));

  assert_full_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && tx_level == 8'(DEPTH)) |=> (tx_level <= $past(tx_level)));

  assert_idle_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_level == 8'd0 && !brk_en) |-> txd);

  assert_req_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_req |=> !tx_req);

  assert_req_at_mark_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_req |-> (tx_level <= trig_threshold(tx_trig)));
endmodule

bind hs_uart_tx hs_uart_tx_chk #(.DEPTH(DEPTH)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_valid (wr_valid),
  .wr_ready (wr_ready),
  .brk_en   (brk_en),
  .tx_trig  (tx_trig),
  .txd      (txd),
  .tx_level (tx_level),
  .tx_req   (tx_req)
);

// File: tb/sim_hs_uart_tx.sv
`timescale 1ns/1ps
module sim_hs_uart_tx;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       wr_valid = 0;
  logic       wr_ready;
  logic [7:0] wr_data = 0;
  logic [7:0] rate = 0;
  logic       brk_en = 0;
  logic [1:0] tx_trig = 0;
  logic       txd;
  logic [7:0] tx_level;
  logic       tx_req;

  int tests = 0, fails = 0, cyc = 0;
  int req_cnt = 0;
  logic [7:0] req_lvl = 0;
  bit done = 0;

  always #10 clk = ~clk;

  hs_uart_tx u0 (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_data(wr_data), .rate(rate), .brk_en(brk_en), .tx_trig(tx_trig),
    .txd(txd), .tx_level(tx_level), .tx_req(tx_req)
  );

  always @(negedge clk) if (rst_n && tx_req) begin
    req_cnt++;
    req_lvl = tx_level;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      fails++;
      $display("FAIL watchdog: actual=%0d cycles expected<150000", cyc);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp, input string what);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] b);
    @(negedge clk);
    wr_valid = 1; wr_data = b;
    @(negedge clk);
    wr_valid = 0;
  endtask

  task automatic get_frame(input int n, output logic [7:0] b, output int lowrun,
                           output logic stop_ok);
    int guard;
    bit contig;
    guard = 0; contig = 1; b = '0; lowrun = 0; stop_ok = 0;
    @(negedge clk);
    while (txd !== 1'b0 && guard < 30000) begin @(negedge clk); guard++; end
    for (int t = 0; t <= n*9 + n/2; t++) begin
      if (contig && txd === 1'b0) lowrun++; else contig = 0;
      if (t >= n && t < n*9 && (t % n) == n/2) b[t/n - 1] = txd;
      if (t == n*9 + n/2) stop_ok = (txd === 1'b1);
      else @(negedge clk);
    end
  endtask

  task automatic drain();
    int g = 0;
    while (tx_level != 0 && g < 40000) begin @(negedge clk); g++; end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1", txd, 1, "txd after reset");
    chk("R1", tx_level, 0, "level after reset");
    chk("R1", wr_ready, 1, "ready after reset");
    chk("R1", tx_req, 0, "req after reset");
  endtask

  task automatic t_single(input logic [7:0] r, input logic [7:0] b);
    logic [7:0] got; int low; logic st; int n;
    n = (int'(r) + 1) * 14;
    rate = r;
    push(b);
    get_frame(n, got, low, st);
    chk("R2", low, n, "start bit length");
    chk("R3", got, b, "frame data LSB first");
    chk("R3", st, 1, "stop bit high");
    repeat (n) @(negedge clk);
    chk("R4", tx_level, 0, "level after frame");
    chk("R3", txd, 1, "idle line high");
  endtask

  task automatic t_order_level();
    logic [7:0] got; int low; logic st;
    rate = 0;
    brk_en = 1;
    push(8'h11); push(8'h82); push(8'hC3);
    chk("R4", tx_level, 3, "level with three queued");
    @(negedge clk); brk_en = 0;
    get_frame(14, got, low, st);
    chk("R6", got, 8'h11, "first byte");
    chk("R4", tx_level, 3, "level during stop bit");
    get_frame(14, got, low, st);
    chk("R6", got, 8'h82, "second byte");
    get_frame(14, got, low, st);
    chk("R6", got, 8'hC3, "third byte");
    repeat (14) @(negedge clk);
    chk("R4", tx_level, 0, "level after drain");
  endtask

  task automatic t_full_break();
    logic [7:0] got; int low; logic st; int highs;
    rate = 0;
    brk_en = 1;
    for (int i = 0; i < 64; i++) push(8'(i) ^ 8'h5A);
    chk("R5", tx_level, 64, "level when full");
    chk("R5", wr_ready, 0, "ready when full");
    push(8'hEE);
    chk("R5", tx_level, 64, "level after refused write");
    highs = 0;
    for (int i = 0; i < 200; i++) begin @(negedge clk); if (txd !== 1'b0) highs++; end
    chk("R8", highs, 0, "line high cycles under break");
    chk("R8", tx_level, 64, "queue held under break");
    brk_en = 0;
    get_frame(14, got, low, st);
    chk("R6", got, 8'h5A, "oldest byte first after break");
    drain();
    chk("R4", tx_level, 0, "level after full drain");
  endtask

  task automatic t_break_midframe();
    int highs;
    rate = 0;
    push(8'hFF);
    repeat (20) @(negedge clk);
    brk_en = 1;
    highs = 0;
    for (int i = 0; i < 300; i++) begin @(negedge clk); if (txd !== 1'b0) highs++; end
    chk("R8", highs, 0, "line high during mid-frame break");
    chk("R8", tx_level, 0, "in-flight frame counted out");
    brk_en = 0;
    @(negedge clk);
    chk("R3", txd, 1, "line high after break released");
  endtask

  task automatic t_req(input logic [1:0] code, input int thr, input int nbytes);
    rate = 0;
    tx_trig = code;
    brk_en = 1;
    for (int i = 0; i < nbytes; i++) push(8'(i + 1));
    @(negedge clk);
    req_cnt = 0; req_lvl = 8'hFF;
    brk_en = 0;
    drain();
    repeat (3) @(negedge clk);
    chk("R7", req_cnt, 1, $sformatf("pulses for code %0d", code));
    chk("R7", req_lvl, thr, $sformatf("level at pulse for code %0d", code));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_single(8'd0, 8'hA5);
    t_single(8'd2, 8'h3B);
    t_order_level();
    t_full_break();
    t_break_midframe();
    t_req(2'd1, 4, 6);
    t_req(2'd0, 0, 2);
    t_req(2'd3, 16, 20);
    t_req(2'd2, 8, 10);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule